// File: doc/BRIEF.md
# Pipeline Hazard and Bypass Unit

This block is the control slice of a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). Each cycle it looks at the two source register numbers of the instruction in decode and at the destinations and write flags of the older instructions in the execute, memory and writeback latches. From these it decides whether decode may advance, whether a bubble has to be inserted, and which bypass path each ALU operand takes. It also clears the two youngest latches when a branch in execute turns out to be mispredicted, and it steers store data from writeback into the memory stage.

The ALU operand selects are worked out one cycle early, while the consumer is still in decode, and registered. They are therefore valid exactly when that consumer sits in execute. All latch controls (PC enable, F/D enable, F/D clear, D/X clear) and the store-data forward are combinational. The datapath, register file and memories live outside the block.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: If a decode source (not zero) equals the destination of the writing instruction in the execute latch and no clear is issued, the registered select for that operand is 2 (take the memory-stage result) in the next cycle. Select codes: 0 = register file, 1 = writeback-stage value, 2 = memory-stage value.
- R2: If no execute-latch match exists but the source equals the destination of the writing instruction in the memory latch, the select in the next cycle is 1. An execute-latch match takes priority over a memory-latch match.
- R3: A producer whose write flag is 0 never causes a match, so with no other match the select is 0.
- R4: Source register 0 never matches, never bypasses and never stalls, even against a producer that writes register 0.
- R5: When the execute instruction is a load with its write flag set and its destination matches either decode source, the unit stalls: pc_en = 0, fd_en = 0, dx_clr = 1, fd_clr = 0.
- R6: In the cycle after a stall or a flush, both operand selects are 0, since the execute stage holds a bubble.
- R7: When ex_redirect is 1 the unit flushes: pc_en = 1, fd_en = 1, fd_clr = 1, dx_clr = 1. This holds even if a load-use stall is requested in the same cycle.
- R8: st_data_fwd is 1 exactly when the memory-stage instruction is a store, its data source is not zero, and it equals the destination of the writing instruction in writeback.
- R9: A decode source that matches only the writeback-latch destination gives select 0. The register file writes before it reads within a cycle, so no bypass is needed.
- R10: While reset is held, both operand selects are 0.
- R11: The stall is evaluated anew every cycle. Once the load has moved to the memory latch, the unit advances (pc_en = 1, dx_clr = 0), and the dependent operand gets select 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_src_a | input | RW | First source register of the decode instruction |
| dec_src_b | input | RW | Second source register of the decode instruction |
| ex_dst | input | RW | Destination of the execute-latch instruction |
| ex_wen | input | 1 | Execute-latch instruction writes a register |
| ex_is_load | input | 1 | Execute-latch instruction is a load |
| ex_redirect | input | 1 | Branch in execute was mispredicted |
| mem_dst | input | RW | Destination of the memory-latch instruction |
| mem_wen | input | 1 | Memory-latch instruction writes a register |
| mem_is_store | input | 1 | Memory-latch instruction is a store |
| mem_store_src | input | RW | Store-data source register in the memory latch |
| wb_dst | input | RW | Destination of the writeback-latch instruction |
| wb_wen | input | 1 | Writeback-latch instruction writes a register |
| opa_sel | output | 2 | Registered ALU operand A select |
| opb_sel | output | 2 | Registered ALU operand B select |
| st_data_fwd | output | 1 | Take store data from writeback |
| pc_en | output | 1 | PC write enable |
| fd_en | output | 1 | F/D latch write enable |
| fd_clr | output | 1 | Clear F/D latch to a no-op |
| dx_clr | output | 1 | Clear D/X latch to a no-op |

## Verification
The operand selects are tested with sources that hit only the execute producer, only the memory producer, both at once, and only the writeback producer. These cases separate the priority order from the write-before-read case. Matches with the write flag cleared and matches on register zero show that neither the flag nor the zero check was dropped. A load-use sequence on each operand, followed by the load moving on, shows both the single-cycle stall and the writeback bypass that comes after it. A flush coinciding with a load-use hazard shows which of the two wins. Last, a long run of random latch contents, drawn from a small range of register numbers so that matches are frequent, is compared cycle by cycle against a behavioural model.

// File: rtl/hzb_pkg.sv
package hzb_pkg;
  typedef enum logic [1:0] {
    OPS_REGFILE  = 2'd0,
    OPS_FROM_WB  = 2'd1,
    OPS_FROM_MEM = 2'd2
  } opsel_e;
endpackage

// File: rtl/hzb_match.sv
// Register-number comparator shared by bypass, stall and store paths.
// Register zero is hardwired and never counts as a producer/consumer pair.
module hzb_match #(
  parameter int RW = 5
) (
  input  logic [RW-1:0] src,
  input  logic [RW-1:0] dst,
  input  logic          wen,
  output logic          hit
);
  always_comb begin
    hit = wen && (src != '0) && (src == dst);
  end
endmodule

// File: rtl/hzb_opsel.sv
// One ALU operand: compares the decode source with the two older
// producers and registers the select so it lines up with execute.
module hzb_opsel
  import hzb_pkg::*;
#(
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] src,
  input  logic [RW-1:0] ex_dst,
  input  logic          ex_wen,
  input  logic [RW-1:0] mem_dst,
  input  logic          mem_wen,
  input  logic          kill,
  output logic          hit_ex,
  output logic [1:0]    sel_o
);
  logic   hit_mem;
  opsel_e sel_d;
  opsel_e sel_q;

  hzb_match #(.RW(RW)) u_m_ex (
    .src(src), .dst(ex_dst), .wen(ex_wen), .hit(hit_ex)
  );

  hzb_match #(.RW(RW)) u_m_mem (
    .src(src), .dst(mem_dst), .wen(mem_wen), .hit(hit_mem)
  );

  // Newest producer first; a killed slot becomes a bubble.
  always_comb begin
    if (kill) begin
      sel_d = OPS_REGFILE;
    end else if (hit_ex) begin
      sel_d = OPS_FROM_MEM;
    end else if (hit_mem) begin
      sel_d = OPS_FROM_WB;
    end else begin
      sel_d = OPS_REGFILE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= OPS_REGFILE;
    end else begin
      sel_q <= sel_d;
    end
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/hzb_flowctl.sv
// Latch enables and clears; a redirect outranks a load-use stall.
module hzb_flowctl (
  input  logic stall_req,
  input  logic redirect,
  output logic pc_en,
  output logic fd_en,
  output logic fd_clr,
  output logic dx_clr
);
  logic stall_eff;

  always_comb begin
    stall_eff = stall_req && !redirect;
    pc_en     = !stall_eff;
    fd_en     = !stall_eff;
    fd_clr    = redirect;
    dx_clr    = redirect || stall_eff;
  end
endmodule

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl #(
  parameter int NUM_REGS = 32,
  localparam int RW = $clog2(NUM_REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] dec_src_a,
  input  logic [RW-1:0] dec_src_b,
  input  logic [RW-1:0] ex_dst,
  input  logic          ex_wen,
  input  logic          ex_is_load,
  input  logic          ex_redirect,
  input  logic [RW-1:0] mem_dst,
  input  logic          mem_wen,
  input  logic          mem_is_store,
  input  logic [RW-1:0] mem_store_src,
  input  logic [RW-1:0] wb_dst,
  input  logic          wb_wen,
  output logic [1:0]    opa_sel,
  output logic [1:0]    opb_sel,
  output logic          st_data_fwd,
  output logic          pc_en,
  output logic          fd_en,
  output logic          fd_clr,
  output logic          dx_clr
);
  localparam int NUM_OPS = 2;

  logic [RW-1:0] src_arr [NUM_OPS];
  logic [1:0]    sel_arr [NUM_OPS];
  logic [NUM_OPS-1:0] hit_ex_vec;
  logic          load_use;
  logic          st_hit;

  assign src_arr[0] = dec_src_a;
  assign src_arr[1] = dec_src_b;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    hzb_opsel #(.RW(RW)) u_opsel (
      .clk    (clk),
      .rst_n  (rst_n),
      .src    (src_arr[g]),
      .ex_dst (ex_dst),
      .ex_wen (ex_wen),
      .mem_dst(mem_dst),
      .mem_wen(mem_wen),
      .kill   (dx_clr),
      .hit_ex (hit_ex_vec[g]),
      .sel_o  (sel_arr[g])
    );
  end

  assign load_use = ex_is_load && (|hit_ex_vec);

  hzb_flowctl u_flow (
    .stall_req(load_use),
    .redirect (ex_redirect),
    .pc_en    (pc_en),
    .fd_en    (fd_en),
    .fd_clr   (fd_clr),
    .dx_clr   (dx_clr)
  );

  hzb_match #(.RW(RW)) u_st_match (
    .src(mem_store_src), .dst(wb_dst), .wen(wb_wen), .hit(st_hit)
  );

  assign st_data_fwd = mem_is_store && st_hit;
  assign opa_sel     = sel_arr[0];
  assign opb_sel     = sel_arr[1];
endmodule

// File: rtl/hzb_checker.sv
module hzb_checker #(
  parameter int RW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [RW-1:0] dec_src_a,
  input logic [RW-1:0] dec_src_b,
  input logic [RW-1:0] ex_dst,
  input logic          ex_wen,
  input logic          ex_is_load,
  input logic          ex_redirect,
  input logic [RW-1:0] mem_dst,
  input logic          mem_wen,
  input logic          wb_wen,
  input logic [1:0]    opa_sel,
  input logic [1:0]    opb_sel,
  input logic          st_data_fwd,
  input logic          pc_en,
  input logic          fd_en,
  input logic          fd_clr,
  input logic          dx_clr
);
  p_exfwd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_wen && dec_src_a != '0 && dec_src_a == ex_dst && !dx_clr) |=> (opa_sel == 2'd2));

  p_memfwd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wen && dec_src_b != '0 && dec_src_b == mem_dst &&
     !(ex_wen && ex_dst == dec_src_b) && !dx_clr) |=> (opb_sel == 2'd1));

  p_zero_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_src_a == '0) |=> (opa_sel == 2'd0));

  p_loaduse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_is_load && ex_wen && ex_dst != '0 &&
     (ex_dst == dec_src_a || ex_dst == dec_src_b) && !ex_redirect)
    |-> (!pc_en && !fd_en && dx_clr && !fd_clr));

  p_bubble_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dx_clr |=> (opa_sel == 2'd0 && opb_sel == 2'd0));

  p_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ex_redirect |-> (pc_en && fd_en && fd_clr && dx_clr));

  p_nowb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_wen |-> !st_data_fwd);

  p_advance_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ex_redirect && !ex_is_load) |-> (pc_en && fd_en && !dx_clr && !fd_clr));
endmodule

bind pipe_hazard_ctl hzb_checker #(.RW(RW)) u_hzb_chk (
  .clk(clk), .rst_n(rst_n), .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
  .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_is_load(ex_is_load),
  .ex_redirect(ex_redirect), .mem_dst(mem_dst), .mem_wen(mem_wen),
  .wb_wen(wb_wen), .opa_sel(opa_sel), .opb_sel(opb_sel),
  .st_data_fwd(st_data_fwd), .pc_en(pc_en), .fd_en(fd_en),
  .fd_clr(fd_clr), .dx_clr(dx_clr)
);

// File: tb/tb_pipe_hazard_ctl.sv
module tb_pipe_hazard_ctl;
  localparam int CLK_P = 10;
  localparam int RW    = 5;

  logic          clk;
  logic          rst_n;
  logic [RW-1:0] dec_src_a, dec_src_b, ex_dst, mem_dst, mem_store_src, wb_dst;
  logic          ex_wen, ex_is_load, ex_redirect, mem_wen, mem_is_store, wb_wen;
  logic [1:0]    opa_sel, opb_sel;
  logic          st_data_fwd, pc_en, fd_en, fd_clr, dx_clr;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  pipe_hazard_ctl #(.NUM_REGS(32)) dut (
    .clk(clk), .rst_n(rst_n), .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
    .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_is_load(ex_is_load),
    .ex_redirect(ex_redirect), .mem_dst(mem_dst), .mem_wen(mem_wen),
    .mem_is_store(mem_is_store), .mem_store_src(mem_store_src),
    .wb_dst(wb_dst), .wb_wen(wb_wen), .opa_sel(opa_sel), .opb_sel(opb_sel),
    .st_data_fwd(st_data_fwd), .pc_en(pc_en), .fd_en(fd_en),
    .fd_clr(fd_clr), .dx_clr(dx_clr)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic idle();
    dec_src_a = '0; dec_src_b = '0; ex_dst = '0; mem_dst = '0;
    mem_store_src = '0; wb_dst = '0; ex_wen = 0; ex_is_load = 0;
    ex_redirect = 0; mem_wen = 0; mem_is_store = 0; wb_wen = 0;
  endtask

  // Behavioural model of one registered operand select.
  function automatic int ref_sel(input logic [RW-1:0] s, input logic [RW-1:0] ed,
                                 input logic ew, input logic [RW-1:0] md,
                                 input logic mw, input logic kill);
    if (kill) return 0;
    if (s != 0 && ew && s == ed) return 2;
    if (s != 0 && mw && s == md) return 1;
    return 0;
  endfunction

  function automatic bit ref_stall();
    bit ha, hb;
    ha = (dec_src_a != 0) && ex_wen && (dec_src_a == ex_dst);
    hb = (dec_src_b != 0) && ex_wen && (dec_src_b == ex_dst);
    return ex_is_load && (ha || hb) && !ex_redirect;
  endfunction

  task automatic flow_chk(input string rq, input int e_pc, input int e_fd,
                          input int e_fdc, input int e_dxc);
    chk(rq, "pc_en", pc_en, e_pc);
    chk(rq, "fd_en", fd_en, e_fd);
    chk(rq, "fd_clr", fd_clr, e_fdc);
    chk(rq, "dx_clr", dx_clr, e_dxc);
  endtask

  task automatic t_reset();
    rst_n = 0;
    idle();
    dec_src_a = 5; ex_dst = 5; ex_wen = 1;
    repeat (2) @(negedge clk);
    #1;
    chk("R10", "opa_sel in reset", opa_sel, 0);
    chk("R10", "opb_sel in reset", opb_sel, 0);
    @(negedge clk);
    idle();
    rst_n = 1;
    @(negedge clk); #1;
    chk("R10", "opa_sel after idle", opa_sel, 0);
  endtask

  task automatic t_ex_bypass();
    @(negedge clk);
    idle();
    dec_src_a = 5; dec_src_b = 7; ex_dst = 5; ex_wen = 1;
    #1 flow_chk("R1", 1, 1, 0, 0);
    @(negedge clk); #1;
    chk("R1", "opa_sel ex match", opa_sel, 2);
    chk("R1", "opb_sel no match", opb_sel, 0);
  endtask

  task automatic t_priority();
    @(negedge clk);
    idle();
    dec_src_a = 9; ex_dst = 9; ex_wen = 1; mem_dst = 9; mem_wen = 1;
    dec_src_b = 12;
    @(negedge clk); #1;
    chk("R2", "opa_sel both match", opa_sel, 2);
    chk("R2", "opb_sel none", opb_sel, 0);
    idle();
    dec_src_b = 11; mem_dst = 11; mem_wen = 1; ex_dst = 3; ex_wen = 1;
    @(negedge clk); #1;
    chk("R2", "opb_sel mem only", opb_sel, 1);
  endtask

  task automatic t_nowrite();
    @(negedge clk);
    idle();
    dec_src_a = 6; ex_dst = 6; ex_wen = 0;
    dec_src_b = 8; mem_dst = 8; mem_wen = 0;
    @(negedge clk); #1;
    chk("R3", "opa_sel ex wen=0", opa_sel, 0);
    chk("R3", "opb_sel mem wen=0", opb_sel, 0);
    idle();
    dec_src_a = 14; wb_dst = 14; wb_wen = 1;
    @(negedge clk); #1;
    chk("R9", "opa_sel wb only", opa_sel, 0);
  endtask

  task automatic t_zero();
    @(negedge clk);
    idle();
    dec_src_a = 0; dec_src_b = 0; ex_dst = 0; ex_wen = 1; ex_is_load = 1;
    mem_dst = 0; mem_wen = 1;
    #1 flow_chk("R4", 1, 1, 0, 0);
    @(negedge clk); #1;
    chk("R4", "opa_sel zero src", opa_sel, 0);
    chk("R4", "opb_sel zero src", opb_sel, 0);
  endtask

  task automatic t_load_use(input bit on_b);
    @(negedge clk);
    idle();
    if (on_b) dec_src_b = 4; else dec_src_a = 4;
    ex_dst = 4; ex_wen = 1; ex_is_load = 1;
    #1 flow_chk("R5", 0, 0, 0, 1);
    @(negedge clk); #1;
    chk("R6", "opa_sel bubble", opa_sel, 0);
    chk("R6", "opb_sel bubble", opb_sel, 0);
    // load has moved on; execute holds the bubble
    ex_dst = 0; ex_wen = 0; ex_is_load = 0; mem_dst = 4; mem_wen = 1;
    #1 flow_chk("R11", 1, 1, 0, 0);
    @(negedge clk); #1;
    if (on_b) chk("R11", "opb_sel after stall", opb_sel, 1);
    else      chk("R11", "opa_sel after stall", opa_sel, 1);
  endtask

  task automatic t_flush();
    @(negedge clk);
    idle();
    dec_src_a = 4; dec_src_b = 4; ex_dst = 4; ex_wen = 1; ex_is_load = 1;
    ex_redirect = 1;
    #1 flow_chk("R7", 1, 1, 1, 1);
    @(negedge clk); #1;
    chk("R7", "opa_sel after flush", opa_sel, 0);
    chk("R7", "opb_sel after flush", opb_sel, 0);
  endtask

  task automatic t_store_fwd();
    @(negedge clk);
    idle();
    mem_is_store = 1; mem_store_src = 6; wb_dst = 6; wb_wen = 1;
    #1 chk("R8", "st fwd match", st_data_fwd, 1);
    wb_wen = 0;
    #1 chk("R8", "st fwd wen=0", st_data_fwd, 0);
    wb_wen = 1; mem_is_store = 0;
    #1 chk("R8", "st fwd not store", st_data_fwd, 0);
    mem_is_store = 1; mem_store_src = 0; wb_dst = 0;
    #1 chk("R8", "st fwd reg zero", st_data_fwd, 0);
  endtask

  task automatic t_random();
    int ea = 0, eb = 0;
    @(negedge clk);
    idle();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); #1;
      chk("R1", "rand opa_sel", opa_sel, ea);
      chk("R2", "rand opb_sel", opb_sel, eb);
      dec_src_a = RW'($urandom_range(0, 3)); dec_src_b = RW'($urandom_range(0, 3));
      ex_dst = RW'($urandom_range(0, 3)); mem_dst = RW'($urandom_range(0, 3));
      wb_dst = RW'($urandom_range(0, 3)); mem_store_src = RW'($urandom_range(0, 3));
      ex_wen = 1'($urandom_range(0, 1)); mem_wen = 1'($urandom_range(0, 1));
      wb_wen = 1'($urandom_range(0, 1)); ex_is_load = 1'($urandom_range(0, 1));
      mem_is_store = 1'($urandom_range(0, 1));
      ex_redirect = ($urandom_range(0, 7) == 0);
      #1;
      begin
        bit st, kill;
        st   = ref_stall();
        kill = st || ex_redirect;
        flow_chk("R5", st ? 0 : 1, st ? 0 : 1, ex_redirect ? 1 : 0, kill ? 1 : 0);
        chk("R8", "rand st fwd", st_data_fwd,
            (mem_is_store && wb_wen && mem_store_src != 0 && mem_store_src == wb_dst) ? 1 : 0);
        ea = ref_sel(dec_src_a, ex_dst, ex_wen, mem_dst, mem_wen, kill);
        eb = ref_sel(dec_src_b, ex_dst, ex_wen, mem_dst, mem_wen, kill);
      end
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    t_reset();
    t_ex_bypass();
    t_priority();
    t_nowrite();
    t_zero();
    t_load_use(0);
    t_load_use(1);
    t_flush();
    t_store_fwd();
    t_random();
    summary();
  end
endmodule